// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a 32-bit core as a ring of overlapping register windows. A 5-bit architectural register number is turned into a physical index. The translation uses a current-window pointer (CWP) that the block keeps itself. Eight registers are global and shared by every window. Each window owns eight locals and eight outs. The ins of a window are the same physical registers as the outs of the window above it, so a caller's outgoing arguments appear as the callee's incoming arguments without any copy.

Two combinational read ports and one clocked write port serve the pipeline. A save request moves the pointer one window down the ring and a restore request moves it one window up. Before either one moves the pointer, the block checks the target window against a window-invalid mask supplied from outside. If the target is marked, the request is refused and an overflow or underflow pulse is raised for the trap logic.

Top module: `winreg_file`

## Requirements
- R1: While reset is low at a clock edge, the pointer returns to 0 and both the overflow and underflow pulses are low after that edge.
- R2: Architectural register 0 always reads as zero on both read ports, including in a cycle that writes to it. Writes to register 0 change nothing.
- R3: Architectural registers 1 to 7 are globals. They name the same storage in every window.
- R4: In window w, registers 8 to 15 (outs) and 16 to 23 (locals) belong to w. Registers 24 to 31 (ins) are the outs of window (w+1) mod 8, in the same order. Every other pairing of window registers is distinct storage.
- R5: A save request alone, whose target window (CWP-1) mod 8 is valid, sets the pointer to that target at the clock edge.
- R6: A restore request alone, whose target window (CWP+1) mod 8 is valid, sets the pointer to that target at the clock edge.
- R7: A save request whose target bit in the invalid mask is 1 leaves the pointer unchanged and drives the overflow output high for exactly the cycle after the request.
- R8: A restore request whose target bit in the invalid mask is 1 leaves the pointer unchanged and drives the underflow output high for exactly the cycle after the request.
- R9: A read of the register being written in the same cycle returns the incoming write data (write-first).
- R10: A write issued in the same cycle as a save or restore is placed using the pointer value from before the move.
- R11: A save and a restore requested together are both ignored: the pointer is unchanged and neither pulse is raised, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| save_i | input | 1 | Request to move the pointer down one window |
| restore_i | input | 1 | Request to move the pointer up one window |
| wim_i | input | 8 | Window-invalid mask, bit n marks window n |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow pulse |
| unf_o | output | 1 | Window underflow pulse |
| rd_a_addr | input | 5 | Read port A architectural register |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 5 | Read port B architectural register |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural register |
| wr_data | input | 32 | Write data |

## Verification
The bench builds the block with its defaults: eight windows, 32-bit data and a reset pointer of 0. With eight windows, eight saves in a row take the pointer through every window and across the 0-to-7 boundary. Eight restores then take it back across the 7-to-0 boundary. On the way, the bench checks that the ins of window 7 alias the outs of window 0. With 32-bit data, every register can hold a value that marks its window and its offset, so a wrong mapping shows up as a wrong value.

// File: rtl/winreg_pkg.sv
`timescale 1ns/1ps
// Package winreg_pkg
// Architectural constants shared by the windowed register file.
// Assumes a 5-bit register number with globals at 0..7, outs at 8..15,
// locals at 16..23 and ins at 24..31.
package winreg_pkg;
    localparam int ARCH_W    = 5;
    localparam int NGLOBAL   = 8;
    localparam int REGS_PER_WIN = 16;  // locals plus outs owned per window
    typedef logic [ARCH_W-1:0] arch_idx_t;
endpackage

// File: rtl/winreg_xlate.sv
`timescale 1ns/1ps
// Module winreg_xlate
// Maps one architectural register number and the window pointer onto a
// physical storage index. Globals pass through unchanged. Window registers
// use ((cwp*16 + r - 8) mod span) + 8, which puts the ins of window w on the
// outs of window w+1.
// Assumes the raw sum stays below twice the span, which holds for NWIN >= 2.
module winreg_xlate
    import winreg_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CWP_W  = $clog2(NWIN),
    parameter int PIDX_W = $clog2(NGLOBAL + NWIN*REGS_PER_WIN)
) (
    input  arch_idx_t          arch_i,
    input  logic [CWP_W-1:0]   cwp_i,
    output logic [PIDX_W-1:0]  pidx_o
);
    localparam int SPAN = NWIN * REGS_PER_WIN;

    int raw;

    // Purpose: fold the window offset into the circular window region.
    always_comb begin
        raw = 0;
        if (int'(arch_i) < NGLOBAL) begin
            pidx_o = PIDX_W'(arch_i);
        end else begin
            raw = int'(cwp_i) * REGS_PER_WIN + int'(arch_i) - NGLOBAL;
            if (raw >= SPAN) raw = raw - SPAN;
            pidx_o = PIDX_W'(raw + NGLOBAL);
        end
    end
endmodule

// File: rtl/winreg_ctrl.sv
`timescale 1ns/1ps
// Module winreg_ctrl
// Holds the current window pointer. Checks save and restore requests against
// the window-invalid mask and raises one-cycle overflow or underflow pulses
// when a request is refused.
// Assumes that a save and a restore in the same cycle cancel each other.
module winreg_ctrl #(
    parameter int NWIN      = 8,
    parameter int CWP_W     = $clog2(NWIN),
    parameter int RESET_CWP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_i,
    input  logic             restore_i,
    input  logic [NWIN-1:0]  wim_i,
    output logic [CWP_W-1:0] cwp_o,
    output logic             ovf_o,
    output logic             unf_o
);
    logic [CWP_W-1:0] cwp_q, cwp_dn, cwp_up;
    logic             ovf_q, unf_q;
    logic             do_save, do_rest, save_bad, rest_bad;

    // Purpose: neighbour windows on the ring and request qualification.
    always_comb begin
        cwp_dn   = (cwp_q == '0) ? CWP_W'(NWIN-1) : cwp_q - 1'b1;
        cwp_up   = (cwp_q == CWP_W'(NWIN-1)) ? '0 : cwp_q + 1'b1;
        do_save  = save_i & ~restore_i;
        do_rest  = restore_i & ~save_i;
        save_bad = wim_i[cwp_dn];
        rest_bad = wim_i[cwp_up];
    end

    // Purpose: pointer update and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q <= CWP_W'(RESET_CWP);
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= do_save & save_bad;
            unf_q <= do_rest & rest_bad;
            if (do_save && !save_bad)      cwp_q <= cwp_dn;
            else if (do_rest && !rest_bad) cwp_q <= cwp_up;
        end
    end

    assign cwp_o = cwp_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // Reference ring arithmetic for the checks, computed by a separate route.
    function automatic logic [CWP_W-1:0] ring_step(input logic [CWP_W-1:0] w, input int d);
        return CWP_W'((int'(w) + NWIN + d) % NWIN);
    endfunction

    a_r5_save_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i) |=> (ovf_q || cwp_q == ring_step($past(cwp_q), -1)));

    a_r6_restore_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i) |=> (unf_q || cwp_q == ring_step($past(cwp_q), 1)));

    a_r7_overflow_holds_cwp: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $stable(cwp_q));

    a_r8_underflow_holds_cwp: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> $stable(cwp_q));

    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_q, unf_q}));

    a_r11_both_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> ($stable(cwp_q) && !ovf_q && !unf_q));
endmodule

// File: rtl/winreg_array.sv
`timescale 1ns/1ps
// Module winreg_array
// Physical storage of the register file. Index 0 is a hard zero with no
// storage behind it. Reads are combinational and write-first: a read index
// that matches the write in the same cycle returns the write data.
// Assumes the indices come from winreg_xlate and are below NPHYS.
module winreg_array #(
    parameter int DATA_W = 32,
    parameter int NPHYS  = 136,
    parameter int PIDX_W = $clog2(NPHYS),
    parameter int NRD    = 2
) (
    input  logic              clk,
    input  logic [PIDX_W-1:0] rd_idx_i  [NRD],
    output logic [DATA_W-1:0] rd_data_o [NRD],
    input  logic              wr_en_i,
    input  logic [PIDX_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    logic [DATA_W-1:0] mem [1:NPHYS-1];
    logic              wr_live;

    // Purpose: a write to the hard-zero slot is dropped.
    assign wr_live = wr_en_i && (wr_idx_i != '0);

    // Purpose: store the write at the clock edge.
    always_ff @(posedge clk) begin
        if (wr_live) mem[wr_idx_i] <= wr_data_i;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Purpose: zero slot, write-first bypass, then stored value.
        always_comb begin
            if (rd_idx_i[p] == '0)                  rd_data_o[p] = '0;
            else if (wr_live && wr_idx_i == rd_idx_i[p]) rd_data_o[p] = wr_data_i;
            else                                    rd_data_o[p] = mem[rd_idx_i[p]];
        end
    end
endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
// Module winreg_file
// Windowed integer register file: a pointer controller, one address
// translator per port and the physical array. The write is translated with
// the pointer value from before any save or restore in the same cycle.
// Assumes that the trap logic acts on the overflow and underflow pulses.
module winreg_file #(
    parameter int NWIN      = 8,
    parameter int DATA_W    = 32,
    parameter int RESET_CWP = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     save_i,
    input  logic                     restore_i,
    input  logic [NWIN-1:0]          wim_i,
    output logic [$clog2(NWIN)-1:0]  cwp_o,
    output logic                     ovf_o,
    output logic                     unf_o,
    input  logic [4:0]               rd_a_addr,
    output logic [DATA_W-1:0]        rd_a_data,
    input  logic [4:0]               rd_b_addr,
    output logic [DATA_W-1:0]        rd_b_data,
    input  logic                     wr_en,
    input  logic [4:0]               wr_addr,
    input  logic [DATA_W-1:0]        wr_data
);
    import winreg_pkg::*;

    localparam int CWP_W  = $clog2(NWIN);
    localparam int NPHYS  = NGLOBAL + NWIN * REGS_PER_WIN;
    localparam int PIDX_W = $clog2(NPHYS);
    localparam int NRD    = 2;

    logic [CWP_W-1:0]  cwp;
    arch_idx_t         rd_arch [NRD];
    logic [PIDX_W-1:0] rd_idx  [NRD];
    logic [DATA_W-1:0] rd_data [NRD];
    logic [PIDX_W-1:0] wr_idx;

    winreg_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W), .RESET_CWP(RESET_CWP)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .wim_i(wim_i), .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Purpose: gather the read port addresses for the generated translators.
    assign rd_arch[0] = rd_a_addr;
    assign rd_arch[1] = rd_b_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_rdx
        winreg_xlate #(.NWIN(NWIN), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) xl_i (
            .arch_i(rd_arch[p]), .cwp_i(cwp), .pidx_o(rd_idx[p])
        );
    end

    winreg_xlate #(.NWIN(NWIN), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) wr_xl_i (
        .arch_i(wr_addr), .cwp_i(cwp), .pidx_o(wr_idx)
    );

    winreg_array #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PIDX_W(PIDX_W), .NRD(NRD)) arr_i (
        .clk(clk), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
    );

    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign cwp_o     = cwp;

    a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_addr == '0) |-> (rd_a_data == '0)) and ((rd_b_addr == '0) |-> (rd_b_data == '0)));

    a_r9_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && wr_addr == rd_a_addr) |-> (rd_a_data == wr_data));

    a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && !save_i && !restore_i) |=>
            ((!wr_en && rd_b_addr == $past(wr_addr)) -> (rd_b_data == $past(wr_data))));

    a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr >= 5'd8) |-> (wr_idx >= PIDX_W'(NGLOBAL) && int'(wr_idx) < NPHYS));
endmodule

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        save = 1'b0, restore = 1'b0, wen = 1'b0;
    logic [7:0]  wim = '0;
    logic [4:0]  ra = '0, rb = '0, waddr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  cwp;
    logic        ovf, unf;
    logic [31:0] rda, rdb;

    int nvec = 0, nerr = 0;
    logic [31:0] mdl [136];
    int  mcwp = 0;
    bit  exp_ovf = 0, exp_unf = 0;

    always #2.5 clk = ~clk;

    winreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .save_i(save), .restore_i(restore), .wim_i(wim),
        .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf),
        .rd_a_addr(ra), .rd_a_data(rda), .rd_b_addr(rb), .rd_b_data(rdb),
        .wr_en(wen), .wr_addr(waddr), .wr_data(wdata)
    );

    // Model index: globals, own outs/locals, ins from the window above.
    function automatic int pidx(int r, int w);
        if (r < 8)  return r;
        if (r < 24) return 8 + w * 16 + (r - 8);
        return 8 + ((w + 1) % 8) * 16 + (r - 24);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(string req, int r);
        ra = 5'(r); rb = 5'(r);
        #0.5;
        chk(req, rda, (r == 0) ? 32'h0 : mdl[pidx(r, mcwp)]);
        chk(req, rdb, (r == 0) ? 32'h0 : mdl[pidx(r, mcwp)]);
    endtask

    task automatic chk_state(string req);
        #0.2;
        chk({req, " cwp"}, 32'(cwp), 32'(mcwp));
        chk({req, " ovf"}, 32'(ovf), 32'(exp_ovf));
        chk({req, " unf"}, 32'(unf), 32'(exp_unf));
    endtask

    // One clock of stimulus; the model follows at the edge.
    task automatic step(bit sv, bit rs, bit we, int wa, logic [31:0] wd);
        int t;
        @(negedge clk);
        save = sv; restore = rs; wen = we; waddr = 5'(wa); wdata = wd;
        @(posedge clk);
        if (we && wa != 0) mdl[pidx(wa, mcwp)] = wd;
        exp_ovf = 0; exp_unf = 0;
        if (sv && !rs) begin
            t = (mcwp + 7) % 8;
            if (wim[t]) exp_ovf = 1; else mcwp = t;
        end else if (rs && !sv) begin
            t = (mcwp + 1) % 8;
            if (wim[t]) exp_unf = 1; else mcwp = t;
        end
        @(negedge clk);
        save = 0; restore = 0; wen = 0;
    endtask

    task automatic t_reset();
        chk_state("R1 reset");
        chk_reg("R2 zero after reset", 0);
    endtask

    task automatic t_globals();
        for (int r = 1; r < 8; r++) step(0, 0, 1, r, 32'hA000_0000 + 32'(r));
        step(0, 0, 1, 0, 32'hDEAD_BEEF);
        chk_reg("R2 write to r0 dropped", 0);
        step(1, 0, 0, 0, 0);
        for (int r = 1; r < 8; r++) chk_reg("R3 globals shared", r);
        step(0, 1, 0, 0, 0);
    endtask

    task automatic t_window_map();
        logic [31:0] outs [8];
        for (int r = 8; r < 32; r++) step(0, 0, 1, r, 32'hB000_0000 + 32'(mcwp * 256 + r));
        for (int r = 0; r < 32; r++) chk_reg("R4 window readback", r);
        for (int i = 0; i < 8; i++) outs[i] = mdl[pidx(8 + i, mcwp)];
        step(1, 0, 0, 0, 0);
        chk_state("R5 save");
        for (int i = 0; i < 8; i++) begin
            ra = 5'(24 + i); #0.3;
            chk("R4 callee ins are caller outs", rda, outs[i]);
        end
        step(0, 1, 0, 0, 0);
        chk_state("R6 restore");
        for (int r = 16; r < 24; r++) chk_reg("R4 locals kept", r);
    endtask

    task automatic t_ring();
        for (int k = 0; k < 8; k++) begin
            for (int r = 8; r < 24; r++) step(0, 0, 1, r, 32'hC000_0000 + 32'(mcwp * 256 + r));
            step(1, 0, 0, 0, 0);
            chk_state("R5 save around ring");
            for (int r = 24; r < 32; r++) chk_reg("R4 ins alias", r);
        end
        for (int k = 0; k < 8; k++) begin
            step(0, 1, 0, 0, 0);
            chk_state("R6 restore around ring");
            for (int r = 8; r < 32; r++) chk_reg("R4 window intact", r);
        end
    endtask

    task automatic t_overflow();
        wim = 8'(1 << ((mcwp + 7) % 8));
        step(1, 0, 0, 0, 0);
        chk_state("R7 overflow");
        step(0, 0, 0, 0, 0);
        chk_state("R7 overflow one cycle");
        wim = '0;
    endtask

    task automatic t_underflow();
        wim = 8'(1 << ((mcwp + 1) % 8));
        step(0, 1, 0, 0, 0);
        chk_state("R8 underflow");
        step(0, 0, 0, 0, 0);
        chk_state("R8 underflow one cycle");
        wim = '0;
    endtask

    task automatic t_bypass();
        @(negedge clk);
        wen = 1; waddr = 5'd17; wdata = 32'h1234_5678; ra = 5'd17; rb = 5'd0;
        #0.5;
        chk("R9 write-first", rda, 32'h1234_5678);
        waddr = 5'd0; ra = 5'd0; #0.3;
        chk("R2 zero while written", rda, 32'h0);
        waddr = 5'd17; ra = 5'd17;
        @(posedge clk);
        mdl[pidx(17, mcwp)] = 32'h1234_5678;
        @(negedge clk);
        wen = 0;
        chk_reg("R9 stored after bypass", 17);
    endtask

    task automatic t_write_on_save();
        step(1, 0, 1, 9, 32'h5A5A_0009);
        chk_state("R10 save with write");
        ra = 5'd25; #0.3;
        chk("R10 write used old window", rda, 32'h5A5A_0009);
        step(0, 1, 1, 18, 32'h6B6B_0018);
        step(1, 0, 0, 0, 0);
        chk_reg("R10 restore with write", 18);
        step(0, 1, 0, 0, 0);
    endtask

    task automatic t_both();
        step(1, 1, 0, 0, 0);
        chk_state("R11 both ignored");
        wim = 8'hFF;
        step(1, 1, 0, 0, 0);
        chk_state("R11 both ignored, all invalid");
        wim = '0;
    endtask

    initial begin
        for (int i = 0; i < 136; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_globals();
        t_window_map();
        t_ring();
        t_overflow();
        t_underflow();
        t_bypass();
        t_write_on_save();
        t_both();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(200000 * 5);
        nvec++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule